// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds two single-width floating-point operands. An operand word holds a sign bit at the top, a biased exponent below it and a fraction in the low bits, with an implicit leading one in front of the fraction. The work is split across four registered stages. The first stage takes the difference of the two exponents. The second stage picks the operand with the larger exponent and shifts the other mantissa right to line the two up. The third stage adds or subtracts the aligned mantissas. The fourth stage normalizes the result and adjusts the exponent.

Because a register sits between every pair of stages, a fresh operand pair may be presented on every clock. The result comes out four cycles later, tagged by its own valid bit. Bits shifted out during alignment or normalization are dropped, so results truncate. An exact zero result is returned as an all-zero word. Rounding modes, special values and denormal inputs are outside this block: every operand is read as a normal number.

Top module: `fpadd_pipe`

## Requirements
- R1: `out_valid` equals the `in_valid` value sampled four rising edges earlier. A new pair is accepted on every cycle, so back-to-back inputs give back-to-back results.
- R2: Operands with equal signs give the sum of magnitudes. The result takes the larger exponent. The smaller mantissa is shifted right by the exponent difference, and the bits shifted out are discarded. With a difference of 23 and default widths, a result of 1.0 plus 2^-23 is returned as 0x3F800001.
- R3: When the exponent difference is 24 (the mantissa width, hidden bit included) or more, the smaller operand's aligned mantissa is zero, so the result equals the larger operand.
- R4: Operands with different signs give the larger magnitude minus the smaller one, and the result carries the sign of the larger-magnitude operand. For example, 0xC0400000 plus 0x40000000 gives 0xBF800000.
- R5: When the mantissa sum carries out of the hidden-bit position, the result mantissa is shifted right by one and the exponent is increased by one. For example, 0x3F800000 plus 0x3F800000 gives 0x40000000.
- R6: When a subtraction leaves leading zeros, the mantissa is shifted left until the hidden bit is set, and the exponent is lowered by the same count.
- R7: A zero mantissa sum gives the result word 0: sign 0, exponent 0 and fraction 0.
- R8: While `rst_n` is low, and on the first four cycles after it is released, `out_valid` is 0, whatever `in_valid` carries during reset.
- R9: The result does not depend on operand order: swapping `op_a` and `op_b` gives the same word. Field layout: bit 31 is the sign, bits 30:23 are the exponent, bits 22:0 are the fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 1+EXP_W+FRAC_W | Truncated sum |

## Verification
The bench builds the adder with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths, the alignment edge at a difference of 23 versus 24, full cancellation, one-position carry-out and deep left shifts after subtraction can all be reached with ordinary operand values. Random exponents are kept in a middle band so that no result wraps the exponent field. Directed pairs then land exactly on the shift boundaries and on sign ties.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } eff_op_e;
endpackage

// File: rtl/fpadd_expdiff.sv
module fpadd_expdiff #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    output logic              s1_v,
    output logic              s1_sa,
    output logic              s1_sb,
    output logic [EXP_W-1:0]  s1_ea,
    output logic [EXP_W-1:0]  s1_eb,
    output logic [MANT_W-1:0] s1_ma,
    output logic [MANT_W-1:0] s1_mb,
    output logic [EXP_W:0]    s1_diff
);
    logic [EXP_W:0] diff_c;

    always_comb begin
        diff_c = {1'b0, op_a[W-2:FRAC_W]} - {1'b0, op_b[W-2:FRAC_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_sa   <= 1'b0;
            s1_sb   <= 1'b0;
            s1_ea   <= '0;
            s1_eb   <= '0;
            s1_ma   <= '0;
            s1_mb   <= '0;
            s1_diff <= '0;
        end else begin
            s1_v    <= in_valid;
            s1_sa   <= op_a[W-1];
            s1_sb   <= op_b[W-1];
            s1_ea   <= op_a[W-2:FRAC_W];
            s1_eb   <= op_b[W-2:FRAC_W];
            s1_ma   <= {1'b1, op_a[FRAC_W-1:0]};
            s1_mb   <= {1'b1, op_b[FRAC_W-1:0]};
            s1_diff <= diff_c;
        end
    end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_v,
    input  logic              s1_sa,
    input  logic              s1_sb,
    input  logic [EXP_W-1:0]  s1_ea,
    input  logic [EXP_W-1:0]  s1_eb,
    input  logic [MANT_W-1:0] s1_ma,
    input  logic [MANT_W-1:0] s1_mb,
    input  logic [EXP_W:0]    s1_diff,
    output logic              s2_v,
    output logic              s2_sbig,
    output logic              s2_ssmall,
    output logic [EXP_W-1:0]  s2_exp,
    output logic [MANT_W-1:0] s2_mbig,
    output logic [MANT_W-1:0] s2_msmall
);
    logic              a_big;
    logic [EXP_W:0]    shamt;
    logic [MANT_W-1:0] m_small_raw;
    logic [MANT_W-1:0] m_small_al;

    always_comb begin
        a_big       = ~s1_diff[EXP_W];
        shamt       = a_big ? s1_diff : (~s1_diff + 1'b1);
        m_small_raw = a_big ? s1_mb : s1_ma;
        if (shamt >= (EXP_W+1)'(MANT_W))
            m_small_al = '0;
        else
            m_small_al = m_small_raw >> shamt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v      <= 1'b0;
            s2_sbig   <= 1'b0;
            s2_ssmall <= 1'b0;
            s2_exp    <= '0;
            s2_mbig   <= '0;
            s2_msmall <= '0;
        end else begin
            s2_v      <= s1_v;
            s2_sbig   <= a_big ? s1_sa : s1_sb;
            s2_ssmall <= a_big ? s1_sb : s1_sa;
            s2_exp    <= a_big ? s1_ea : s1_eb;
            s2_mbig   <= a_big ? s1_ma : s1_mb;
            s2_msmall <= m_small_al;
        end
    end
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_v,
    input  logic              s2_sbig,
    input  logic              s2_ssmall,
    input  logic [EXP_W-1:0]  s2_exp,
    input  logic [MANT_W-1:0] s2_mbig,
    input  logic [MANT_W-1:0] s2_msmall,
    output logic              s3_v,
    output logic              s3_sign,
    output logic [EXP_W-1:0]  s3_exp,
    output logic [MANT_W:0]   s3_sum
);
    eff_op_e         op;
    logic [MANT_W:0] sum_c;
    logic            sign_c;

    always_comb begin
        op     = (s2_sbig == s2_ssmall) ? OP_ADD : OP_SUB;
        sum_c  = '0;
        sign_c = s2_sbig;
        unique case (op)
            OP_ADD: begin
                sum_c  = {1'b0, s2_mbig} + {1'b0, s2_msmall};
                sign_c = s2_sbig;
            end
            OP_SUB: begin
                if (s2_mbig >= s2_msmall) begin
                    sum_c  = {1'b0, s2_mbig} - {1'b0, s2_msmall};
                    sign_c = s2_sbig;
                end else begin
                    sum_c  = {1'b0, s2_msmall} - {1'b0, s2_mbig};
                    sign_c = s2_ssmall;
                end
            end
            default: begin
                sum_c  = '0;
                sign_c = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_sign <= 1'b0;
            s3_exp  <= '0;
            s3_sum  <= '0;
        end else begin
            s3_v    <= s2_v;
            s3_sign <= sign_c;
            s3_exp  <= s2_exp;
            s3_sum  <= sum_c;
        end
    end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int LZ_W   = $clog2(MANT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s3_v,
    input  logic             s3_sign,
    input  logic [EXP_W-1:0] s3_exp,
    input  logic [MANT_W:0]  s3_sum,
    output logic             out_valid,
    output logic [W-1:0]     out_sum
);
    logic [LZ_W-1:0]   lz;
    logic              found;
    logic [MANT_W-1:0] m_norm;
    logic [EXP_W-1:0]  e_norm;
    logic [W-1:0]      res_c;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (s3_sum[i]) found = 1'b1;
                else           lz    = lz + LZ_W'(1);
            end
        end
    end

    always_comb begin
        m_norm = '0;
        e_norm = '0;
        res_c  = '0;
        if (s3_sum == '0) begin
            res_c = '0;
        end else if (s3_sum[MANT_W]) begin
            m_norm = s3_sum[MANT_W:1];
            e_norm = s3_exp + 1'b1;
            res_c  = {s3_sign, e_norm, m_norm[FRAC_W-1:0]};
        end else begin
            m_norm = s3_sum[MANT_W-1:0] << lz;
            e_norm = s3_exp - EXP_W'(lz);
            res_c  = {s3_sign, e_norm, m_norm[FRAC_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= s3_v;
            out_sum   <= res_c;
        end
    end
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] out_sum
);
    logic              s1_v, s1_sa, s1_sb;
    logic [EXP_W-1:0]  s1_ea, s1_eb;
    logic [MANT_W-1:0] s1_ma, s1_mb;
    logic [EXP_W:0]    s1_diff;

    logic              s2_v, s2_sbig, s2_ssmall;
    logic [EXP_W-1:0]  s2_exp;
    logic [MANT_W-1:0] s2_mbig, s2_msmall;

    logic              s3_v, s3_sign;
    logic [EXP_W-1:0]  s3_exp;
    logic [MANT_W:0]   s3_sum;

    fpadd_expdiff #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_expdiff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .s1_v(s1_v), .s1_sa(s1_sa), .s1_sb(s1_sb), .s1_ea(s1_ea), .s1_eb(s1_eb),
        .s1_ma(s1_ma), .s1_mb(s1_mb), .s1_diff(s1_diff)
    );

    fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n), .s1_v(s1_v), .s1_sa(s1_sa), .s1_sb(s1_sb),
        .s1_ea(s1_ea), .s1_eb(s1_eb), .s1_ma(s1_ma), .s1_mb(s1_mb), .s1_diff(s1_diff),
        .s2_v(s2_v), .s2_sbig(s2_sbig), .s2_ssmall(s2_ssmall), .s2_exp(s2_exp),
        .s2_mbig(s2_mbig), .s2_msmall(s2_msmall)
    );

    fpadd_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsub (
        .clk(clk), .rst_n(rst_n), .s2_v(s2_v), .s2_sbig(s2_sbig), .s2_ssmall(s2_ssmall),
        .s2_exp(s2_exp), .s2_mbig(s2_mbig), .s2_msmall(s2_msmall),
        .s3_v(s3_v), .s3_sign(s3_sign), .s3_exp(s3_exp), .s3_sum(s3_sum)
    );

    fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .s3_v(s3_v), .s3_sign(s3_sign), .s3_exp(s3_exp),
        .s3_sum(s3_sum), .out_valid(out_valid), .out_sum(out_sum)
    );
endmodule

// File: rtl/fpadd_pipe_chk.sv
module fpadd_pipe_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [W-1:0]      out_sum,
    input logic              s1_v,
    input logic [EXP_W:0]    s1_diff,
    input logic              s2_v,
    input logic [MANT_W-1:0] s2_msmall,
    input logic              s3_v,
    input logic [EXP_W-1:0]  s3_exp,
    input logic [MANT_W:0]   s3_sum
);
    logic [2:0]     since_rst;
    logic [EXP_W:0] diff_mag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst < 3'd4) since_rst <= since_rst + 3'd1;
    end

    always_comb diff_mag = s1_diff[EXP_W] ? (~s1_diff + 1'b1) : s1_diff;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    p_far_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && diff_mag >= (EXP_W+1)'(MANT_W)) |=> (s2_v && s2_msmall == '0));

    p_carry_bump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_v && s3_sum[MANT_W]) |=>
        (out_valid && out_sum[W-2:FRAC_W] == EXP_W'($past(s3_exp) + 1'b1)));

    p_zero_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_v && s3_sum == '0) |=> (out_valid && out_sum == '0));

    p_early_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd0) |-> !out_valid);
endmodule

bind fpadd_pipe fpadd_pipe_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_sum(out_sum), .s1_v(s1_v), .s1_diff(s1_diff), .s2_v(s2_v),
    .s2_msmall(s2_msmall), .s3_v(s3_v), .s3_exp(s3_exp), .s3_sum(s3_sum)
);

// File: tb/fpadd_pipe_tb.sv
`timescale 1ns/1ps
module fpadd_pipe_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic        out_valid;
    logic [31:0] out_sum;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    logic        hv [4];
    logic [31:0] hd [4];
    string       hr [4];

    always #2.5 clk = ~clk;

    fpadd_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
        logic        sb, ss;
        int          eb, es, d, e;
        logic [25:0] mb, ms, s;
        logic        sign;
        if (a[30:23] >= b[30:23]) begin
            sb = a[31]; eb = a[30:23]; mb = {3'b001, a[22:0]};
            ss = b[31]; es = b[30:23]; ms = {3'b001, b[22:0]};
        end else begin
            sb = b[31]; eb = b[30:23]; mb = {3'b001, b[22:0]};
            ss = a[31]; es = a[30:23]; ms = {3'b001, a[22:0]};
        end
        d = eb - es;
        ms = (d >= 24) ? 26'd0 : (ms >> d);
        if (sb == ss) begin s = mb + ms; sign = sb; end
        else if (mb >= ms) begin s = mb - ms; sign = sb; end
        else begin s = ms - mb; sign = ss; end
        e = eb;
        if (s == 0) return 32'd0;
        if (s[24]) begin s = s >> 1; e = e + 1; end
        else begin
            while (!s[23]) begin s = s << 1; e = e - 1; end
        end
        return {sign, 8'(e), s[22:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] e, input string req);
        @(negedge clk);
        if (hv[3]) begin
            check(out_valid === 1'b1, "R1", "valid", {31'd0, out_valid}, 32'd1);
            check(out_sum === hd[3], hr[3], "sum", out_sum, hd[3]);
        end else begin
            check(out_valid === 1'b0, "R1", "idle", {31'd0, out_valid}, 32'd0);
        end
        for (int i = 3; i > 0; i--) begin
            hv[i] = hv[i-1]; hd[i] = hd[i-1]; hr[i] = hr[i-1];
        end
        in_valid = v; op_a = a; op_b = b;
        hv[0] = v; hd[0] = e; hr[0] = req;
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] r;
        logic [7:0]  ex;
        r  = $urandom;
        ex = 8'(40 + ($urandom % 170));
        return {r[31], ex, r[22:0]};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, m;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hd[i] = '0; hr[i] = "R1"; end
        rst_n = 1'b0; in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
        repeat (3) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R8", "valid in reset", {31'd0, out_valid}, 32'd0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R8: first cycles after reset are idle (history is empty)
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0, "R8");

        // Directed corner cases, back to back
        step(1'b1, 32'h3F800000, 32'h3F800000, 32'h40000000, "R5");
        step(1'b1, 32'h3F800000, 32'hBF800000, 32'h00000000, "R7");
        step(1'b1, 32'hBF800000, 32'h3F800000, 32'h00000000, "R7");
        step(1'b1, 32'h40400000, 32'hC0000000, 32'h3F800000, "R6");
        step(1'b1, 32'hC0400000, 32'h40000000, 32'hBF800000, "R4");
        step(1'b1, 32'h40000000, 32'hC0400000, 32'hBF800000, "R4");
        step(1'b1, 32'h3F800000, 32'h34000000, 32'h3F800001, "R2");
        step(1'b1, 32'h3F800000, 32'h33800000, 32'h3F800000, "R3");
        step(1'b1, 32'h33800000, 32'hBF800000, 32'hBF800000, "R3");
        step(1'b1, 32'h3F800001, 32'hBF800000, 32'h34000000, "R6");
        step(1'b1, 32'h3FC00000, 32'h3FC00000, 32'h40400000, "R5");
        step(1'b1, 32'h3FC00000, 32'h3E800000, 32'h3FE00000, "R2");

        // Random traffic with gaps and swapped pairs
        for (int i = 0; i < 600; i++) begin
            a = rnd_op();
            b = rnd_op();
            if (($urandom % 4) == 0) b[30:23] = a[30:23];
            if (($urandom % 8) == 0) b = {~a[31], a[30:0]};
            m = model(a, b);
            if (($urandom % 5) == 0) step(1'b0, a, b, '0, "R1");
            step(1'b1, a, b, m, "R2");
            step(1'b1, b, a, m, "R9");
        end
        for (int i = 0; i < 5; i++) step(1'b0, '0, '0, '0, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule